// File: doc/BRIEF.md
# Pipelined Fixed-Point Square Root

This block takes a signed two's-complement fixed-point sample and returns its non-negative square root in a second fixed-point format of its own choosing. The integer and fraction widths of the input and of the output are independent parameters. It is a fully pipelined digit-by-digit extractor: every register stage settles one root bit from one pair of radicand bits. A new sample may enter on every clock, and each result leaves a fixed number of cycles later with a valid flag beside it.

The radicand is placed so that its binary point sits on an even bit boundary, which also covers odd input fraction widths. The root is first built to an internal precision set by the input format. It is then brought to the output fraction width, either by truncation or by round-half-up, as a parameter selects. A result too large for the output format is clamped to the largest positive code and flagged. A negative input produces zero, also flagged. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `fxsqrt_pipe`

## Requirements
- R1: A code of width I+F (I integer bits, F fraction bits) stands for its two's-complement value divided by 2^F. The input format (WII, WIF) and the output format (WOI, WOF) are set independently, and a valid output code is never negative.
- R2: For a non-negative input x, the root is first formed as Q = floor(sqrt(x)·2^P), where P = WIF + WII/2 + 1 − ceil(WII/2). With ROUND=0, the output is Q shifted right by P−WOF when P > WOF, and Q shifted left by WOF−P otherwise.
- R3: With ROUND=1 and P > WOF, the output is Q shifted right by P−WOF, plus the last bit that the shift removes (round half up).
- R4: If the formatted root exceeds 2^(WOI+WOF−1)−1, the output is that value and overflow is 1; otherwise overflow is 0 for a non-negative input.
- R5: A negative input gives an output of zero with overflow set to 1.
- R6: A sample presented with in_valid=1 in cycle c appears with out_valid=1 in cycle c+WII/2+WIF+2. out_valid is 0 in every other cycle, and one sample is accepted every cycle.
- R7: Odd input fraction widths are handled by aligning the radicand to an even bit pair, with no loss of accuracy.
- R8: out_data and overflow keep their values in every cycle in which out_valid is 0.
- R9: While rst_n is low, out_valid, out_data and overflow are 0, and they clear as soon as rst_n falls, with no clock edge needed. The block accepts samples from the second rising edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | WII+WIF | Signed fixed-point radicand |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | WOI+WOF | Fixed-point root |
| overflow | output | 1 | Result saturated, or input was negative |

## Verification
Two instances are driven together. One has an 8.8 input, an 8.8 output and rounding, so its results are due 14 cycles after a sample is presented. The other has an 8.5 input, a 3.4 output and truncation, so its results are due 11 cycles later. For each instance the reference model keeps a queue that starts with exactly that many idle entries and pops one entry on every falling edge. Each result is therefore compared in the one cycle it is due, and in idle cycles the bench checks that valid is low and the previous result is held. Samples arrive back to back, with gaps and with random values, and include the saturation boundary, negative inputs and an asynchronous reset in the middle of a stream.

// File: rtl/fxsqrt_pkg.sv
package fxsqrt_pkg;

  // number of root bits (and pipeline stages) for a given input format
  function automatic int root_bits(input int wii, input int wif);
    return wii / 2 + wif + 1;
  endfunction

  // fraction bits carried by the internal root
  function automatic int root_frac_bits(input int wii, input int wif);
    return wii / 2 + wif + 1 - (wii + 1) / 2;
  endfunction

endpackage

// File: rtl/fxsqrt_stage.sv
module fxsqrt_stage #(
  parameter int N  = 13,
  parameter int WR = 26
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_i,
  input  logic          neg_i,
  input  logic [WR-1:0] rad_i,
  input  logic [N:0]    rem_i,
  input  logic [N-1:0]  root_i,
  output logic          v_o,
  output logic          neg_o,
  output logic [WR-1:0] rad_o,
  output logic [N:0]    rem_o,
  output logic [N-1:0]  root_o
);
  localparam int RW = N + 3;

  logic [RW-1:0] rem_sh, trial, rem_n;
  logic [N-1:0]  root_n;
  logic [WR-1:0] rad_n;
  logic          ge;

  // one root bit: bring down a bit pair, try (2*root)*2+1
  always_comb begin
    rem_sh = {rem_i, rad_i[WR-1 -: 2]};
    trial  = {1'b0, root_i, 2'b01};
    ge     = (rem_sh >= trial);
    rem_n  = ge ? (rem_sh - trial) : rem_sh;
    root_n = N'({root_i, ge});
    rad_n  = rad_i << 2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      neg_o  <= neg_i;
      rad_o  <= rad_n;
      rem_o  <= (N+1)'(rem_n);
      root_o <= root_n;
    end
  end
endmodule

// File: rtl/fxsqrt_fmt.sv
module fxsqrt_fmt #(
  parameter int N     = 13,
  parameter int RF    = 9,
  parameter int WOF   = 8,
  parameter int WO    = 16,
  parameter bit ROUND = 1'b1
)(
  input  logic [N-1:0]  root,
  input  logic          neg,
  output logic [WO-1:0] res,
  output logic          ovf
);
  localparam int UP   = (WOF > RF) ? (WOF - RF) : 0;
  localparam int DROP = (RF > WOF) ? (RF - WOF) : 0;
  localparam int WT   = N + 1 + UP;
  localparam int CW   = ((WT > WO) ? WT : WO) + 1;
  localparam logic [CW-1:0] MAXP = CW'({(WO-1){1'b1}});

  logic [WT-1:0] scaled;
  logic          big;

  generate
    if (DROP > 0) begin : g_drop
      always_comb begin
        scaled = WT'(root >> DROP);
        if (ROUND) scaled = scaled + WT'(root[DROP-1]);
      end
    end else begin : g_keep
      always_comb scaled = WT'(root) << UP;
    end
  endgenerate

  always_comb begin
    big = (CW'(scaled) > MAXP);
    if (neg)      res = '0;
    else if (big) res = WO'(MAXP);
    else          res = WO'(scaled);
    ovf = neg | big;
  end
endmodule

// File: rtl/fxsqrt_pipe.sv
module fxsqrt_pipe
  import fxsqrt_pkg::*;
#(
  parameter int WII   = 8,
  parameter int WIF   = 8,
  parameter int WOI   = 8,
  parameter int WOF   = 8,
  parameter bit ROUND = 1'b1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [WII+WIF-1:0] in_data,
  output logic               out_valid,
  output logic [WOI+WOF-1:0] out_data,
  output logic               overflow
);
  localparam int WI    = WII + WIF;
  localparam int WO    = WOI + WOF;
  localparam int RF    = root_frac_bits(WII, WIF);
  localparam int N     = root_bits(WII, WIF);
  localparam int WR    = 2 * N;
  localparam int SHIFT = 2 * RF - WIF;

  // reset: asynchronous assert, two-flop synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // radicand alignment: binary point lands on an even bit pair
  logic          in_neg;
  logic [WR-1:0] rad_init;
  always_comb begin
    in_neg   = in_data[WI-1];
    rad_init = '0;
    if (!in_neg) rad_init = WR'(in_data[WI-2:0]) << SHIFT;
  end

  logic          v_a    [N+1];
  logic          n_a    [N+1];
  logic [WR-1:0] rad_a  [N+1];
  logic [N:0]    rem_a  [N+1];
  logic [N-1:0]  root_a [N+1];

  assign v_a[0]    = in_valid;
  assign n_a[0]    = in_neg;
  assign rad_a[0]  = rad_init;
  assign rem_a[0]  = '0;
  assign root_a[0] = '0;

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      fxsqrt_stage #(.N(N), .WR(WR)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n_s),
        .v_i    (v_a[i]),
        .neg_i  (n_a[i]),
        .rad_i  (rad_a[i]),
        .rem_i  (rem_a[i]),
        .root_i (root_a[i]),
        .v_o    (v_a[i+1]),
        .neg_o  (n_a[i+1]),
        .rad_o  (rad_a[i+1]),
        .rem_o  (rem_a[i+1]),
        .root_o (root_a[i+1])
      );
    end
  endgenerate

  logic [WO-1:0] fmt_res;
  logic          fmt_ovf;

  fxsqrt_fmt #(.N(N), .RF(RF), .WOF(WOF), .WO(WO), .ROUND(ROUND)) u_fmt (
    .root (root_a[N]),
    .neg  (n_a[N]),
    .res  (fmt_res),
    .ovf  (fmt_ovf)
  );

  logic [WO-1:0] out_d;
  logic          ovf_d;
  always_comb begin
    out_d = out_data;
    ovf_d = overflow;
    if (v_a[N]) begin
      out_d = fmt_res;
      ovf_d = fmt_ovf;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      overflow  <= 1'b0;
    end else begin
      out_valid <= v_a[N];
      out_data  <= out_d;
      overflow  <= ovf_d;
    end
  end
endmodule

// File: rtl/fxsqrt_chk.sv
module fxsqrt_chk #(
  parameter int WO  = 16,
  parameter int LAT = 14
)(
  input logic          clk,
  input logic          rst_i,
  input logic          in_valid,
  input logic          in_sign,
  input logic          out_valid,
  input logic [WO-1:0] out_data,
  input logic          overflow
);
  logic [LAT-1:0] vsr, nsr;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      vsr <= '0;
      nsr <= '0;
    end else begin
      vsr <= {vsr[LAT-2:0], in_valid};
      nsr <= {nsr[LAT-2:0], in_valid & in_sign};
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_i) out_valid == vsr[LAT-1]); // R6
  AST_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_i) (out_valid && nsr[LAT-1]) |-> (overflow && out_data == '0)); // R5
  AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_i) (out_valid && overflow) |-> (out_data == '0 || out_data == {1'b0, {(WO-1){1'b1}}})); // R4
  AST_NON_NEGATIVE: assert property (@(posedge clk) disable iff (!rst_i) out_valid |-> !out_data[WO-1]); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_i) !out_valid |-> ($stable(out_data) && $stable(overflow))); // R8
endmodule

bind fxsqrt_pipe fxsqrt_chk #(.WO(WOI + WOF), .LAT(WII / 2 + WIF + 2)) u_chk (
  .clk       (clk),
  .rst_i     (rst_n_s),
  .in_valid  (in_valid),
  .in_sign   (in_data[WII+WIF-1]),
  .out_valid (out_valid),
  .out_data  (out_data),
  .overflow  (overflow)
);

// File: tb/tb_fxsqrt_pipe.sv
`timescale 1ns/1ps
module tb_fxsqrt_pipe;
  localparam int LAT_A = 14;  // 8/2 + 8 + 2
  localparam int LAT_B = 11;  // 8/2 + 5 + 2

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_a;
  logic [12:0] in_b;
  logic        ov_a, ov_b, fl_a, fl_b;
  logic [15:0] out_a;
  logic [6:0]  out_b;

  always #4 clk = ~clk;

  fxsqrt_pipe dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_a),
    .out_valid(ov_a), .out_data(out_a), .overflow(fl_a));

  fxsqrt_pipe #(.WII(8), .WIF(5), .WOI(3), .WOF(4), .ROUND(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_b),
    .out_valid(ov_b), .out_data(out_b), .overflow(fl_b));

  typedef struct { bit v; longint o; bit f; string tag; } exp_t;
  exp_t   qa[$], qb[$];
  int     tests = 0, fails = 0;
  bit     done = 1'b0;
  longint last_a, last_b;
  bit     lastf_a, lastf_b;

  function automatic longint isqrt(input longint v);
    longint r = 0;
    for (int b = 31; b >= 0; b--) begin
      longint t = r | (longint'(1) <<< b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  function automatic void ref_root(input longint x, input int wii, input int wif,
                                   input int woi, input int wof, input bit rnd,
                                   output longint o, output bit ov);
    int p = wif + wii / 2 + 1 - (wii + 1) / 2;
    longint q, maxp;
    if (x < 0) begin o = 0; ov = 1'b1; return; end
    q = isqrt(x <<< (2 * p - wif));
    if (p > wof) begin
      o = q >>> (p - wof);
      if (rnd) o = o + ((q >>> (p - wof - 1)) & 1);
    end else o = q <<< (wof - p);
    maxp = (longint'(1) <<< (woi + wof - 1)) - 1;
    ov = 1'b0;
    if (o > maxp) begin o = maxp; ov = 1'b1; end
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint got, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
    end
  endtask

  task automatic compare_outputs();
    exp_t ea, eb;
    ea = qa.pop_front();
    eb = qb.pop_front();
    if (ea.v) begin
      chk(ov_a == 1'b1, "R6", "A out_valid", ov_a, 1);
      chk(longint'(out_a) == ea.o, ea.tag, "A out_data", longint'(out_a), ea.o);
      chk(fl_a == ea.f, ea.tag, "A overflow", fl_a, ea.f);
      last_a = ea.o; lastf_a = ea.f;
    end else begin
      chk(ov_a == 1'b0, "R6", "A out_valid idle", ov_a, 0);
      chk(longint'(out_a) == last_a && fl_a == lastf_a, "R8", "A hold", longint'(out_a), last_a);
    end
    if (eb.v) begin
      chk(ov_b == 1'b1, "R6", "B out_valid", ov_b, 1);
      chk(longint'(out_b) == eb.o, eb.tag, "B out_data", longint'(out_b), eb.o);
      chk(fl_b == eb.f, eb.tag, "B overflow", fl_b, eb.f);
      last_b = eb.o; lastf_b = eb.f;
    end else begin
      chk(ov_b == 1'b0, "R6", "B out_valid idle", ov_b, 0);
      chk(longint'(out_b) == last_b && fl_b == lastf_b, "R8", "B hold", longint'(out_b), last_b);
    end
  endtask

  task automatic cycle(input bit v, input logic [15:0] da, input logic [12:0] db);
    exp_t ea, eb;
    longint xa, xb;
    @(negedge clk);
    compare_outputs();
    in_valid = v; in_a = da; in_b = db;
    xa = longint'($signed(da));
    xb = longint'($signed(db));
    ea.v = v; eb.v = v;
    ref_root(xa, 8, 8, 8, 8, 1'b1, ea.o, ea.f);
    ref_root(xb, 8, 5, 3, 4, 1'b0, eb.o, eb.f);
    ea.tag = (xa < 0) ? "R5" : "R1/R3";
    eb.tag = (xb < 0) ? "R5" : (eb.f ? "R4" : "R2/R7");
    qa.push_back(ea);
    qb.push_back(eb);
  endtask

  task automatic start_model();
    exp_t idle;
    idle.v = 1'b0; idle.o = 0; idle.f = 1'b0; idle.tag = "R6";
    qa.delete(); qb.delete();
    repeat (LAT_A) qa.push_back(idle);
    repeat (LAT_B) qb.push_back(idle);
    last_a = 0; last_b = 0; lastf_a = 1'b0; lastf_b = 1'b0;
  endtask

  task automatic reset_release();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    start_model();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    chk(ov_a == 0 && out_a == 0 && fl_a == 0, "R9", "A reset state", longint'(out_a), 0);
    chk(ov_b == 0 && out_b == 0 && fl_b == 0, "R9", "B reset state", longint'(out_b), 0);
    reset_release();

    // directed corner values, back to back
    cycle(1, 16'h0000, 13'h0000);  // zero
    cycle(1, 16'h0001, 13'h0020);  // smallest positive / B 1.0
    cycle(1, 16'h0100, 13'h01FF);  // A 1.0 / B just under 16.0
    cycle(1, 16'h0200, 13'h0200);  // A 2.0 / B 16.0 saturates
    cycle(1, 16'h0400, 13'h0FFF);  // A 4.0 / B max positive
    cycle(1, 16'h7FFF, 13'h1FFF);  // A max / B -1 lsb
    cycle(1, 16'hFFFF, 13'h1000);  // negatives
    cycle(1, 16'h8000, 13'h0001);
    cycle(1, 16'h15C3, 13'h0064);
    cycle(0, 16'h1234, 13'h0123);  // idle with junk data
    cycle(0, 16'h0000, 13'h0000);
    cycle(1, 16'h0300, 13'h0060);
    cycle(0, 16'h0000, 13'h0000);
    cycle(1, 16'h0003, 13'h0003);

    for (int i = 0; i < 400; i++)
      cycle(($urandom % 10) < 7, 16'($urandom), 13'($urandom));
    repeat (LAT_A + 2) cycle(0, 16'h0, 13'h0);

    // asynchronous reset in the middle of a stream
    for (int i = 0; i < 8; i++) cycle(1, 16'($urandom & 16'h7FFF), 13'($urandom & 13'h0FFF));
    repeat (LAT_B) cycle(0, 16'h0, 13'h0);
    #2 rst_n = 1'b0;
    #1;
    chk(ov_a == 0 && out_a == 0 && fl_a == 0, "R9", "A async clear", longint'(out_a), 0);
    chk(ov_b == 0 && out_b == 0 && fl_b == 0, "R9", "B async clear", longint'(out_b), 0);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    reset_release();
    for (int i = 0; i < 40; i++) cycle(1, 16'($urandom), 13'($urandom));
    repeat (LAT_A + 2) cycle(0, 16'h0, 13'h0);

    finish_run();
  end
endmodule